// File: doc/BRIEF.md
# Per-Channel Hit Phase Histogram

This block builds a histogram of hit arrival times for a single detector channel. Every master-clock cycle it receives a hit flag, the 5-bit phase measured by the channel's time-to-digital converter, the converter's configured resolution (slices per clock period) and the running 12-bit bunch-crossing number. Each accepted hit adds one to a single bin counter. The bin is chosen either by the measured phase or by the bunch number, as configured.

The counter storage is a bank of wide words. It can be used as one counter per word, or, when the converter resolution is finer than the word count, as two half-width counters per word, which doubles the number of bins. When any counter reaches its all-ones value, the whole bank stops counting. It stays stopped until a synchronous clear or a reset. A registered read port returns one storage word per cycle, and a status output shows the stopped state.

Top module: `phase_hist`

## Requirements
- R1: Reset or clear sets every storage word to zero and drives `frozen_o` low.
- R2: In a cycle with `hit_i` low, no storage word changes.
- R3: Normal layout, phase selection: a hit adds one to word `phase_i` as a single CNT_W-bit counter. A hit whose phase is NUM_WORDS (16) or more is discarded.
- R4: When an update brings the counter it touches to all ones, `frozen_o` rises after that clock edge. That counter keeps its all-ones value, and no word changes again until clear or reset.
- R5: The split layout is in force only when `cfg_split_i` is high and `tdc_res_i` is greater than NUM_WORDS. Otherwise the normal layout is used even if `cfg_split_i` is high.
- R6: Split layout: bin k (0 to 2*NUM_WORDS-1) is held in word k>>1. Even k uses bits [CNT_W/2-1:0] and odd k uses bits [CNT_W-1:CNT_W/2].
- R7: Split layout: a half-width counter that reaches all ones triggers the freeze. It never carries into the other half of its word.
- R8: With `cfg_bx_sel_i` high, the bin index is the full 12-bit `bxid_i`, and `phase_i` has no effect. Hits with `bxid_i` at or above the active bin count (16 normal, 32 split) are ignored. This works in both layouts.
- R9: `clear_i` takes priority over a hit in the same cycle and releases the freeze.
- R10: `rd_data_o` shows the word selected by `rd_addr_i` one clock edge after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst | input | 1 | synchronous active-high reset |
| hit_i | input | 1 | hit present this cycle |
| phase_i | input | 5 | measured phase of the hit |
| tdc_res_i | input | 6 | configured converter resolution |
| bxid_i | input | 12 | current bunch-crossing number |
| cfg_split_i | input | 1 | request the split (half-width) layout |
| cfg_bx_sel_i | input | 1 | select bins by bunch number instead of phase |
| clear_i | input | 1 | synchronous clear of counters and freeze |
| rd_addr_i | input | 4 | storage word to read |
| rd_data_o | output | 24 | registered storage word |
| frozen_o | output | 1 | counting stopped by saturation |

## Verification
Several properties are checked on every cycle. The freeze must persist until clear, and clear must release it. A written word must never read back as zero, so a counter cannot wrap. The bin-valid strobe must depend on the hit flag. Bunch-selected bins must stay below the active window. The split layout may engage only above the resolution threshold. Some behaviours need the bench's scenarios: the exact bin-to-word and half mapping, discarding of out-of-range phases, saturation of a full-width or half-width counter, the no-carry rule, and clear winning over a simultaneous hit. The bench checks these against a reference model, using directed corners and seeded random traffic with the counter width reduced so that saturation is reachable.

// File: rtl/hist_pkg.sv
package hist_pkg;
  typedef enum logic {LAYOUT_NORMAL = 1'b0, LAYOUT_SPLIT = 1'b1} layout_e;

  function automatic int unsigned active_bins(input int unsigned words, input layout_e lay);
    return (lay == LAYOUT_SPLIT) ? 2 * words : words;
  endfunction
endpackage

// File: rtl/hist_bin_sel.sv
module hist_bin_sel
  import hist_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int PHASE_W   = 5,
  parameter int BX_W      = 12,
  parameter int RES_W     = 6,
  parameter int BIN_W     = $clog2(2 * NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [BX_W-1:0]  bxid_i,
  input  logic [RES_W-1:0] res_i,
  input  logic             split_req_i,
  input  logic             bx_sel_i,
  output layout_e          layout_o,
  output logic             bin_vld_o,
  output logic [BIN_W-1:0] bin_o
);
  localparam logic [RES_W-1:0] RES_THR = RES_W'(NUM_WORDS);
  localparam logic [BX_W-1:0]  LIM_N   = BX_W'(active_bins(NUM_WORDS, LAYOUT_NORMAL));
  localparam logic [BX_W-1:0]  LIM_S   = BX_W'(active_bins(NUM_WORDS, LAYOUT_SPLIT));

  logic [BX_W-1:0] src;
  logic [BX_W-1:0] limit;

  always_comb begin
    layout_o  = (split_req_i && (res_i > RES_THR)) ? LAYOUT_SPLIT : LAYOUT_NORMAL;
    src       = bx_sel_i ? bxid_i : BX_W'(phase_i);
    limit     = (layout_o == LAYOUT_SPLIT) ? LIM_S : LIM_N;
    bin_vld_o = hit_i && (src < limit);
    bin_o     = src[BIN_W-1:0];
  end

  // R2: no bin strobe without a hit
  p_hit_gate_r2: assert property (@(posedge clk) disable iff (rst)
    !hit_i |-> !bin_vld_o);
  // R8: bunch-selected bins stay inside the widest window
  p_bx_window_r8: assert property (@(posedge clk) disable iff (rst)
    (bin_vld_o && bx_sel_i) |-> (bxid_i < LIM_S));
  // R5: split layout only above the resolution threshold
  p_split_res_r5: assert property (@(posedge clk) disable iff (rst)
    (layout_o == LAYOUT_SPLIT) |-> (res_i > RES_THR));
endmodule

// File: rtl/hist_cnt_bank.sv
module hist_cnt_bank
  import hist_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int CNT_W     = 24,
  parameter int BIN_W     = $clog2(2 * NUM_WORDS),
  parameter int ADDR_W    = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              upd_i,
  input  layout_e           layout_i,
  input  logic [BIN_W-1:0]  bin_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CNT_W-1:0]  rd_data_o,
  output logic              frozen_o
);
  localparam int HALF_W = CNT_W / 2;
  localparam logic [CNT_W-1:0]  W_ONE = CNT_W'(1);
  localparam logic [HALF_W-1:0] H_ONE = HALF_W'(1);

  logic [CNT_W-1:0]  mem [NUM_WORDS];
  logic [CNT_W-1:0]  rd_q;
  logic              frozen_q;
  logic [ADDR_W-1:0] widx;
  logic              hsel;
  logic [CNT_W-1:0]  cur;
  logic [CNT_W-1:0]  nxt;
  logic              hit_full;
  logic              upd_eff;

  always_comb begin
    widx     = (layout_i == LAYOUT_SPLIT) ? bin_i[BIN_W-1:1] : bin_i[ADDR_W-1:0];
    hsel     = bin_i[0];
    cur      = mem[widx];
    nxt      = cur;
    hit_full = 1'b0;
    if (layout_i == LAYOUT_NORMAL) begin
      nxt      = cur + W_ONE;
      hit_full = &nxt;
    end else if (hsel) begin
      nxt[CNT_W-1:HALF_W] = cur[CNT_W-1:HALF_W] + H_ONE;
      hit_full            = &nxt[CNT_W-1:HALF_W];
    end else begin
      nxt[HALF_W-1:0] = cur[HALF_W-1:0] + H_ONE;
      hit_full        = &nxt[HALF_W-1:0];
    end
    upd_eff = upd_i && !frozen_q && !clr_i;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '0;
      frozen_q <= 1'b0;
    end else if (upd_eff) begin
      mem[widx] <= nxt;
      if (hit_full) frozen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= mem[rd_addr_i];
  end

  assign rd_data_o = rd_q;
  assign frozen_o  = frozen_q;

  // R4: freeze persists until clear
  p_frozen_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (frozen_q && !clr_i) |=> frozen_q);
  // R4: an updated word never wraps back to zero
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    upd_eff |=> (mem[$past(widx)] != '0));
  // R9: clear releases the freeze and empties storage
  p_clear_release_r9: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (!frozen_q && mem[0] == '0));
endmodule

// File: rtl/phase_hist.sv
module phase_hist
  import hist_pkg::*;
#(
  parameter int NUM_WORDS = 16,
  parameter int CNT_W     = 24,
  parameter int PHASE_W   = 5,
  parameter int BX_W      = 12,
  parameter int RES_W     = 6,
  localparam int BIN_W    = $clog2(2 * NUM_WORDS),
  localparam int ADDR_W   = $clog2(NUM_WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hit_i,
  input  logic [PHASE_W-1:0] phase_i,
  input  logic [RES_W-1:0]   tdc_res_i,
  input  logic [BX_W-1:0]    bxid_i,
  input  logic               cfg_split_i,
  input  logic               cfg_bx_sel_i,
  input  logic               clear_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [CNT_W-1:0]   rd_data_o,
  output logic               frozen_o
);
  layout_e          layout;
  logic             bin_vld;
  logic [BIN_W-1:0] bin;

  hist_bin_sel #(
    .NUM_WORDS(NUM_WORDS), .PHASE_W(PHASE_W), .BX_W(BX_W),
    .RES_W(RES_W), .BIN_W(BIN_W)
  ) u_sel (
    .clk(clk), .rst(rst), .hit_i(hit_i), .phase_i(phase_i),
    .bxid_i(bxid_i), .res_i(tdc_res_i), .split_req_i(cfg_split_i),
    .bx_sel_i(cfg_bx_sel_i), .layout_o(layout), .bin_vld_o(bin_vld),
    .bin_o(bin)
  );

  hist_cnt_bank #(
    .NUM_WORDS(NUM_WORDS), .CNT_W(CNT_W), .BIN_W(BIN_W), .ADDR_W(ADDR_W)
  ) u_bank (
    .clk(clk), .rst(rst), .clr_i(clear_i), .upd_i(bin_vld),
    .layout_i(layout), .bin_i(bin), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .frozen_o(frozen_o)
  );
endmodule

// File: tb/phase_hist_bench.sv
module phase_hist_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hit = 1'b0;
  logic [4:0] phase = '0;
  logic [5:0] res = 6'd16;
  logic [11:0] bxid = '0;
  logic split = 1'b0;
  logic bxsel = 1'b0;
  logic clr = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [W-1:0] rd_data;
  logic frozen;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_m [16];
  bit exp_frz = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_hist #(.CNT_W(W)) u_phase_hist (
    .clk(clk), .rst(rst), .hit_i(hit), .phase_i(phase), .tdc_res_i(res),
    .bxid_i(bxid), .cfg_split_i(split), .cfg_bx_sel_i(bxsel), .clear_i(clr),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .frozen_o(frozen)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic model(input bit h, input logic [4:0] ph, input logic [5:0] rs,
                       input logic [11:0] bx, input bit e, input bit bm, input bit c);
    bit sp;
    int src, nb, w, sh;
    logic [3:0] half;
    sp  = e && (rs > 6'd16);
    src = bm ? int'(bx) : int'(ph);
    nb  = sp ? 32 : 16;
    if (c) begin
      for (int i = 0; i < 16; i++) exp_m[i] = '0;
      exp_frz = 1'b0;
    end else if (h && !exp_frz && src < nb) begin
      if (!sp) begin
        exp_m[src] = exp_m[src] + 1'b1;
        if (exp_m[src] == 8'hFF) exp_frz = 1'b1;
      end else begin
        w = src >> 1; sh = (src & 1) * 4;
        half = 4'((exp_m[w] >> sh) & 8'h0F) + 4'd1;
        if (sh == 0) exp_m[w][3:0] = half; else exp_m[w][7:4] = half;
        if (half == 4'hF) exp_frz = 1'b1;
      end
    end
  endtask

  task automatic step(input bit h, input logic [4:0] ph, input logic [5:0] rs,
                      input logic [11:0] bx, input bit e, input bit bm, input bit c);
    @(negedge clk);
    hit = h; phase = ph; res = rs; bxid = bx; split = e; bxsel = bm; clr = c;
    @(posedge clk);
    model(h, ph, rs, bx, e, bm, c);
  endtask

  // R10: word appears on rd_data_o one edge after rd_addr_i
  task automatic check_all(input string tag);
    @(negedge clk);
    hit = 1'b0; clr = 1'b0;
    chk(frozen === exp_frz, {tag, " frozen"}, int'(frozen), int'(exp_frz));
    for (int w = 0; w < 16; w++) begin
      rd_addr = 4'(w);
      @(negedge clk);
      chk(rd_data === exp_m[w], {tag, " R10 word"}, int'(rd_data), int'(exp_m[w]));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) exp_m[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    check_all("R1 reset");

    repeat (5) step(1'b0, 5'd3, 6'd16, 12'd0, 1'b0, 1'b0, 1'b0);
    check_all("R2 no hit");

    repeat (3) step(1'b1, 5'd3, 6'd16, 12'd0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 5'd15, 6'd16, 12'd0, 1'b0, 1'b0, 1'b0);
    step(1'b1, 5'd20, 6'd16, 12'd0, 1'b0, 1'b0, 1'b0);
    check_all("R3 phase normal");

    step(1'b1, 5'd20, 6'd16, 12'd0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 5'd1, 6'd16, 12'd0, 1'b1, 1'b0, 1'b0);
    check_all("R5 split gated by res");

    step(1'b1, 5'd7, 6'd20, 12'd0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 5'd30, 6'd32, 12'd0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 5'd30, 6'd32, 12'd0, 1'b1, 1'b0, 1'b0);
    check_all("R6 split map");

    step(1'b1, 5'd9, 6'd16, 12'd5, 1'b0, 1'b1, 1'b0);
    step(1'b1, 5'd9, 6'd16, 12'd16, 1'b0, 1'b1, 1'b0);
    step(1'b1, 5'd9, 6'd16, 12'd40, 1'b1, 1'b1, 1'b0);
    step(1'b1, 5'd9, 6'd32, 12'd21, 1'b1, 1'b1, 1'b0);
    step(1'b1, 5'd9, 6'd32, 12'h815, 1'b1, 1'b1, 1'b0);
    check_all("R8 bx select");

    step(1'b1, 5'd0, 6'd16, 12'd0, 1'b0, 1'b0, 1'b1);
    check_all("R9 clear over hit");

    repeat (15) step(1'b1, 5'd0, 6'd24, 12'd0, 1'b1, 1'b0, 1'b0);
    step(1'b1, 5'd2, 6'd24, 12'd0, 1'b1, 1'b0, 1'b0);
    check_all("R7 half saturate");

    step(1'b0, 5'd0, 6'd16, 12'd0, 1'b0, 1'b0, 1'b1);
    repeat (255) step(1'b1, 5'd2, 6'd16, 12'd0, 1'b0, 1'b0, 1'b0);
    repeat (4) step(1'b1, 5'd5, 6'd16, 12'd0, 1'b0, 1'b0, 1'b0);
    check_all("R4 full saturate");

    step(1'b0, 5'd0, 6'd16, 12'd0, 1'b0, 1'b0, 1'b1);
    check_all("R9 clear release");

    void'($urandom(32'd1234));
    for (int blk = 0; blk < 16; blk++) begin
      bit e, bm;
      logic [5:0] rs;
      e  = 1'($urandom);
      bm = 1'($urandom);
      case ($urandom % 4)
        0: rs = 6'd12;
        1: rs = 6'd16;
        2: rs = 6'd20;
        default: rs = 6'd32;
      endcase
      for (int n = 0; n < 200; n++) begin
        step(1'($urandom), 5'($urandom), rs, 12'($urandom % 40), e, bm,
             ($urandom % 300) == 0);
      end
      check_all("R3 R6 R8 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule